// File: doc/BRIEF.md
# PHY Management Transaction Controller

This block runs one station-management transaction towards an Ethernet PHY each time the host writes a 32-bit command word. The word selects read or write, a 5-bit PHY address and a 5-bit register number, and for writes carries 16 bits of data. The controller serialises a clause-22 management frame on the MDC clock and the MDIO data line. It drives a 32-bit preamble of ones, the start pattern, the opcode, both addresses and the turnaround, then 16 data bits MSB first. On a read it releases MDIO from the turnaround onwards and captures the PHY's data bits.

Completion is reported through the same word. A ready bit is set, read data replaces the low half, and a one-cycle interrupt pulse is raised if the word asked for one. MDC is a divided copy of the system clock. A parameter sets the half-period, and an elaboration check keeps the resulting rate under a configurable ceiling. The host reads the word through a registered read strobe.

Top module: `mgmt_ctl`

## Requirements
- R1: After reset the command word reads as zero, MDC is low, MDIO is not driven (output enable 0) and no interrupt pulse occurs.
- R2: A write word with opcode 01 in bits 27:26 produces, one bit per MDC period and sampled by the PHY on MDC rising edges, 32 ones, 0,1, 0,1, PHY address bits 25:21 MSB first, register bits 20:16 MSB first, 1,0, then data bits 15:0 MSB first, with MDIO driven for all 64 bits.
- R3: A word with opcode 10 produces the same header with opcode bits 1,0. MDIO is driven for the first 46 bits and released for the turnaround and the 16 data bits. The 16 bits present on MDIO at the MDC rising edges of the data phase are stored MSB first into bits 15:0 of the word.
- R4: An accepted write clears bit 28 (ready) and stores bits 29:16 and 15:0. When the frame ends, bit 28 is set and bits 29:16 read back unchanged. After a write transaction, bits 15:0 also read back unchanged.
- R5: At completion, done_irq pulses high for exactly one system clock if bit 29 of the word was set, and stays low if it was clear.
- R6: Bits 31:30 of the word always read as zero.
- R7: A host write while a transaction is in progress is ignored. The running frame and the stored word are unchanged.
- R8: A host write with opcode 00 or 11 is ignored. No MDC edge occurs and the stored word is unchanged.
- R9: MDC has a period of 2*MDC_HALF system clocks with each high phase MDC_HALF clocks long. MDC is low whenever no transaction runs, and MDIO changes only while MDC is low.
- R10: host_rdata presents the word as it stood at the clock edge where host_rd was sampled high, and holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for the command word |
| host_rd | input | 1 | Read strobe for the command word |
| host_wdata | input | 32 | Command word written by the host |
| host_rdata | output | 32 | Registered read value of the command word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable (1 = controller drives) |
| mdio_i | input | 1 | MDIO value seen on the line |
| done_irq | output | 1 | One-cycle completion interrupt event |

## Verification
The embedded properties watch several things on every cycle: the exact length of each MDC high phase, MDIO holding still while MDC is high, MDC resting low when idle, the interrupt being a single-cycle pulse that coincides with ready, and the stored word staying frozen across writes made during a transaction. Other behaviours appear only in the bench's scenarios, which use a PHY model that records every bit at MDC rising edges and returns data during reads. These are the bit-exact frame contents, the release of MDIO in the read turnaround, the captured read data landing in the low half, the rejection of invalid opcodes, and the presence or absence of the interrupt for a given enable bit.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;
   localparam int WORD_W = 32;

   localparam logic [1:0] OP_WR = 2'b01;
   localparam logic [1:0] OP_RD = 2'b10;

   // Field placement of the command word, bit 29 down to bit 0.
   typedef struct packed {
      logic              irq_en;
      logic              ready;
      logic [1:0]        op;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regn;
      logic [DATA_W-1:0] data;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/mgmt_clkdiv.sv
module mgmt_clkdiv #(
   parameter int HALF = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);
   logic tick;

   generate
      if (HALF == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (!run)        cnt <= '0;
            else if (tick)        cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == CW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mdc <= 1'b0;
      else if (!run)  mdc <= 1'b0;
      else if (tick)  mdc <= ~mdc;
   end

   assign rise = tick && !mdc;
   assign fall = tick && mdc;
endmodule

// File: rtl/mgmt_frame.sv
module mgmt_frame
   import mgmt_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] phy,
   input  logic [ADDR_W-1:0] regn,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_data,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
   localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
   localparam int DATA_POS  = TA_POS + 2;
   localparam int KW        = $clog2(FRAME_LEN);

   logic [FRAME_LEN-1:0] shreg;
   logic [KW-1:0]        bit_k;
   logic                 rd_mode;
   logic                 in_release;

   assign in_release = rd_mode && (bit_k >= KW'(TA_POS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_k   <= '0;
         rd_mode <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
         rx_data <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            shreg   <= {{PRE_LEN{1'b1}}, 2'b01, op, phy, regn, 2'b10, wdata};
            bit_k   <= '0;
            rd_mode <= (op == OP_RD);
            busy    <= 1'b1;
         end else if (busy) begin
            if (rise && rd_mode && (bit_k >= KW'(DATA_POS)))
               rx_data <= {rx_data[DATA_W-2:0], mdio_i};
            if (fall) begin
               if (bit_k == KW'(FRAME_LEN - 1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bit_k <= bit_k + 1'b1;
                  shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign mdio_o  = busy ? shreg[FRAME_LEN-1] : 1'b1;
   assign mdio_oe = busy && !in_release;

   // R4: completion only follows an active frame
   p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
endmodule

// File: rtl/mgmt_ctl.sv
module mgmt_ctl
   import mgmt_pkg::*;
#(
   parameter int SYS_CLK_HZ = 50_000_000,
   parameter int MDC_MAX_HZ = 2_500_000,
   parameter int MDC_HALF   = 10,
   parameter int PRE_LEN    = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic        host_rd,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i,
   output logic        done_irq
);
   generate
      if (MDC_HALF < 1) begin : g_bad_half
         $error("MDC_HALF must be at least 1");
      end
      if (longint'(SYS_CLK_HZ) > longint'(MDC_MAX_HZ) * 2 * MDC_HALF) begin : g_bad_rate
         $error("MDC_HALF too small for the MDC rate ceiling");
      end
      if (CTL_W + 2 != WORD_W) begin : g_bad_word
         $error("command word layout does not fill 32 bits");
      end
   endgenerate

   ctl_t              ctl_q;
   ctl_t              wr_word;
   logic              busy, seq_done, op_ok, accept;
   logic              rise, fall;
   logic [DATA_W-1:0] rx_data;
   logic [31:0]       rdata_q;
   logic              irq_q;

   assign wr_word = ctl_t'(host_wdata[CTL_W-1:0]);
   assign op_ok   = (wr_word.op == OP_WR) || (wr_word.op == OP_RD);
   assign accept  = host_wr && !busy && !seq_done && op_ok;

   mgmt_clkdiv #(.HALF(MDC_HALF)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .mdc  (mdc),
      .rise (rise),
      .fall (fall)
   );

   mgmt_frame #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .op     (wr_word.op),
      .phy    (wr_word.phy),
      .regn   (wr_word.regn),
      .wdata  (wr_word.data),
      .rise   (rise),
      .fall   (fall),
      .mdio_i (mdio_i),
      .busy   (busy),
      .done   (seq_done),
      .rx_data(rx_data),
      .mdio_o (mdio_o),
      .mdio_oe(mdio_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= seq_done && ctl_q.irq_en;
         if (accept) begin
            ctl_q       <= wr_word;
            ctl_q.ready <= 1'b0;
         end else if (seq_done) begin
            ctl_q.ready <= 1'b1;
            if (ctl_q.op == OP_RD) ctl_q.data <= rx_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (host_rd) rdata_q <= {2'b00, ctl_q};
   end

   assign host_rdata = rdata_q;
   assign done_irq   = irq_q;

   // checker counter: length of the current MDC high phase
   logic [15:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_cnt <= '0;
      else if (mdc) hi_cnt <= hi_cnt + 1'b1;
      else          hi_cnt <= '0;
   end

   p_mdc_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc) |-> (hi_cnt == 16'(MDC_HALF)));

   p_mdio_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> $stable(mdio_o));

   p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !seq_done) |-> !mdc);

   p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);

   p_irq_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> (ctl_q.ready && ctl_q.irq_en));

   p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_wr) |=> $stable({ctl_q.irq_en, ctl_q.op, ctl_q.phy, ctl_q.regn, ctl_q.data}));
endmodule

// File: tb/mgmt_ctl_tb.sv
module mgmt_ctl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 2;
   localparam int NVEC       = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_i, done_irq;

   mgmt_ctl #(.SYS_CLK_HZ(10_000_000), .MDC_MAX_HZ(2_500_000), .MDC_HALF(HALF), .PRE_LEN(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .done_irq(done_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;
   int sys_cyc = 0, irq_n = 0;
   int cnt = 0, prev_rise = 0, last_rise = 0;
   logic [63:0] obs_d, obs_oe;
   logic [15:0] phy_val = 16'h0;

   always @(posedge clk) begin
      sys_cyc++;
      if (done_irq) irq_n++;
   end

   // PHY model: records each bit at MDC rise, answers reads in the data phase
   always @(posedge mdc) begin
      if (cnt < 64) begin
         obs_d[63-cnt]  = mdio_o;
         obs_oe[63-cnt] = mdio_oe;
      end
      prev_rise = last_rise;
      last_rise = sys_cyc;
      cnt++;
   end

   always_comb begin
      if (cnt >= 48 && cnt < 64) mdio_i = phy_val[63-cnt];
      else                       mdio_i = 1'b1;
   end

   // {op, phy, reg, data, irq_en}
   localparam logic [28:0] VEC [NVEC] = '{
      {2'b01, 5'h01, 5'h00, 16'hA5C3, 1'b1},
      {2'b10, 5'h1F, 5'h1F, 16'h5A3C, 1'b1},
      {2'b10, 5'h00, 5'h02, 16'hFFFF, 1'b0},
      {2'b01, 5'h10, 5'h11, 16'h0001, 1'b0},
      {2'b10, 5'h05, 5'h0A, 16'h0000, 1'b1},
      {2'b01, 5'h1F, 5'h1F, 16'hFFFF, 1'b1}
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [31:0] w);
      @(negedge clk); host_wr = 1'b1; host_wdata = w;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic host_read(output logic [31:0] r);
      @(negedge clk); host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
      r = host_rdata;
   endtask

   task automatic wait_ready(output logic [31:0] r);
      for (int i = 0; i < 3000; i++) begin
         host_read(r);
         if (r[28]) break;
      end
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [63:0] frame_of(input logic [1:0] op, input logic [4:0] p,
                                            input logic [4:0] g, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, op, p, g, 2'b10, d};
   endfunction

   initial begin
      repeat (3000 * NVEC + 20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", sys_cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r, w, expw, keep;
      logic [63:0] ef, eoe, msk;
      int irq0, c0;

      repeat (4) @(negedge clk);
      // R1: reset state
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins in reset", {62'd0, mdc, mdio_oe}, 64'd0);
      rst_n = 1'b1;
      host_read(r);
      check(r == 32'd0, "R1 word after reset", r, 0);
      check(irq_n == 0, "R1 no irq", irq_n, 0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         logic [1:0] op; logic [4:0] p, g; logic [15:0] d; logic ie;
         {op, p, g, d, ie} = VEC[v];
         phy_val = d;
         w = {2'b11, ie, 1'b1, op, p, g, (op == 2'b10) ? ~d : d};
         irq0 = irq_n;
         cnt = 0;
         host_write(w);
         host_read(r);
         // R10 / R4: immediate read shows fields with ready cleared
         expw = {2'b00, ie, 1'b0, op, p, g, w[15:0]};
         check(r == expw, "R4 R10 ready cleared on start", r, expw);
         wait_ready(r);
         ef  = frame_of(op, p, g, d);
         eoe = (op == 2'b10) ? {46'h3FFF_FFFF_FFFF, 18'd0} : 64'hFFFF_FFFF_FFFF_FFFF;
         msk = (op == 2'b10) ? {46'h3FFF_FFFF_FFFF, 18'd0} : 64'hFFFF_FFFF_FFFF_FFFF;
         if (op == 2'b01) check((obs_d & msk) == (ef & msk), "R2 write frame bits", obs_d, ef);
         else             check((obs_d & msk) == (ef & msk), "R3 read header bits", obs_d & msk, ef & msk);
         check(obs_oe == eoe, (op == 2'b10) ? "R3 mdio release" : "R2 mdio driven", obs_oe, eoe);
         expw = {2'b00, ie, 1'b1, op, p, g, d};
         check(r == expw, (op == 2'b10) ? "R3 R4 read data returned" : "R4 R6 completion word", r, expw);
         check((irq_n - irq0) == (ie ? 1 : 0), "R5 irq per enable", irq_n - irq0, ie ? 1 : 0);
         check((last_rise - prev_rise) == 2 * HALF, "R9 mdc period", last_rise - prev_rise, 2 * HALF);
         check(cnt == 64, "R2 R3 bit count", cnt, 64);
      end

      // R7: write during a transaction is ignored
      cnt = 0;
      phy_val = 16'h0;
      w = {2'b00, 1'b0, 1'b0, 2'b01, 5'h03, 5'h04, 16'h1234};
      host_write(w);
      repeat (30) @(negedge clk);
      host_write({2'b00, 1'b1, 1'b0, 2'b10, 5'h1E, 5'h1D, 16'hBEEF});
      wait_ready(r);
      ef = frame_of(2'b01, 5'h03, 5'h04, 16'h1234);
      check(obs_d == ef, "R7 frame untouched by busy write", obs_d, ef);
      expw = {2'b00, 1'b0, 1'b1, 2'b01, 5'h03, 5'h04, 16'h1234};
      check(r == expw, "R7 word untouched by busy write", r, expw);
      keep = r;

      // R8: invalid opcodes ignored
      c0 = cnt;
      host_write({2'b00, 1'b1, 1'b0, 2'b00, 5'h07, 5'h07, 16'h7777});
      repeat (40) @(negedge clk);
      check(cnt == c0 && mdc == 1'b0, "R8 op 00 no frame", cnt, c0);
      host_read(r);
      check(r == keep, "R8 op 00 word kept", r, keep);
      host_write({2'b00, 1'b1, 1'b0, 2'b11, 5'h09, 5'h09, 16'h8888});
      repeat (40) @(negedge clk);
      check(cnt == c0 && mdio_oe == 1'b0, "R8 op 11 no frame", cnt, c0);
      host_read(r);
      check(r == keep, "R8 op 11 word kept", r, keep);

      // R10: output holds between read strobes
      repeat (5) @(negedge clk);
      check(host_rdata == keep, "R10 rdata holds", host_rdata, keep);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule